// File: doc/BRIEF.md
# SCSI DMA Channel Register Engine

This block is the register file and control core of a bus-master DMA channel that works next to a SCSI protocol engine. Software programs a start byte count, a start memory address and a start descriptor-list address. It then issues a command. The start command copies those values into working registers and enables the channel. The idle command disables the channel. The abort command asks the protocol engine to cancel its request.

As the protocol engine moves data, it raises transfer requests that carry a direction and a length. The block accepts a request only when the direction agrees with the programmed direction. It trims the length to the bytes that remain, then moves the working count and working address by that amount. A command-complete pulse empties the count and flags completion. A small status register records completion, abort and direction errors. A mode input selects how status is cleared: by writing ones, or as a side effect of reading it. The core's interrupt line shows in status reads but is never stored. Two enable bits in the command word decide which events drive the interrupt output.

Top module: `scsi_dma_regs`

## Requirements
- R1: After reset, reads return 0 for the command (index 0), working count (3) and status (5, with core interrupt low), 0xFFFFFFFF for the working address (4) and 0xFFFFFFFD for the working descriptor address (7). The DMA enable output is low.
- R2: Indices 0, 1, 2 and 6 (command, start count, start address, start descriptor address) read back what was last written. Writes to indices 3, 4 and 7 leave those registers unchanged.
- R3: A command write with bits [1:0] = 3 (start) copies index 1 into 3, index 2 into 4 and index 6 into 7. It clears the stored status bits and raises the DMA enable output from the next cycle.
- R4: A command write with bits [1:0] = 0 (idle) lowers DMA enable. A write with bits [1:0] = 1 (blast) changes neither enable nor counters. A write with bits [1:0] = 2 (abort) raises abortReq during that write cycle and sets status bit 2.
- R5: A transfer request whose direction (xferToMem, 1 meaning device to memory) equals command bit 7 is accepted in the same cycle. The granted length is the smaller of the request length and the working count. The working count then drops by that amount and the working address rises by it.
- R6: A transfer request whose direction differs from command bit 7 is not accepted and has a granted length of 0. It leaves the working count and address unchanged and sets status bit 1 (error).
- R7: A cmdDone pulse sets the working count to 0 and sets status bit 3 (done).
- R8: A status read returns bit 4 equal to the coreIrq input in that cycle. Bits 0, 5 and above read 0. Bit 4 is never held.
- R9: With rdClearMode low, a status write clears each of bits 1 to 3 where the written data has a 1. It leaves the others as they were.
- R10: With rdClearMode high, status writes are ignored. A status read returns the current bits 1 to 3 and clears them for later reads.
- R11: irqOut is high when status bit 3 and command bit 6 are both set, or when coreIrq and command bit 5 are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for clear-on-read) |
| regIdx | input | 3 | Register word index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regIdx, combinational |
| rdClearMode | input | 1 | 1: status clears on read; 0: write-one-to-clear |
| xferReq | input | 1 | Transfer request from the protocol engine |
| xferToMem | input | 1 | Request direction, 1 = device to memory |
| xferLen | input | 32 | Requested length in bytes |
| xferAccept | output | 1 | Request accepted this cycle |
| xferGrantLen | output | 32 | Granted length, 0 when not accepted |
| coreIrq | input | 1 | Interrupt flag of the protocol engine |
| cmdDone | input | 1 | Command-complete pulse |
| dmaEnable | output | 1 | Channel enabled by start, disabled by idle |
| abortReq | output | 1 | Cancel request, high during an abort command write |
| irqOut | output | 1 | Channel interrupt |

## Verification
The bench aims at the length clamp: a request larger than the remaining count, and one made when the count is already zero. A design that failed to clamp would let the count wrap below zero and push the address past the buffer. The bench also sends requests against the programmed direction; a design that accepted them would move data the wrong way, and one that ignored the error flag would hide the fault. Both status clearing modes are run with the core interrupt high. A design that stored bit 4, cleared status on read in write-clear mode, or took writes in read-clear mode returns stale or missing flags on a later read. Writes to the working registers and blast commands are issued between reads; a design that let them through would corrupt a transfer in progress.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int IDX_W = 3;
  localparam int ST_W  = 3;  // stored status: [0]=error(bit1), [1]=abort(bit2), [2]=done(bit3)

  localparam logic [IDX_W-1:0] IDX_CMD    = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ST_CNT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_ST_ADR = 3'd2;
  localparam logic [IDX_W-1:0] IDX_WK_CNT = 3'd3;
  localparam logic [IDX_W-1:0] IDX_WK_ADR = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STATUS = 3'd5;
  localparam logic [IDX_W-1:0] IDX_ST_MDL = 3'd6;
  localparam logic [IDX_W-1:0] IDX_WK_MDL = 3'd7;

  localparam int CMD_DIR_BIT   = 7;
  localparam int CMD_IEDONE    = 6;
  localparam int CMD_IECORE    = 5;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dmaOp_e;

  typedef struct packed {
    logic            cmdWr;
    logic            startGo;
    logic            abortGo;
    logic            stCntWr;
    logic            stAdrWr;
    logic            stMdlWr;
    logic [ST_W-1:0] statClr;
    logic            xferGo;
    logic            xferBad;
  } dmaStrobe_t;
endpackage

// File: rtl/scsi_dma_ctrl.sv
module scsi_dma_ctrl
  import scsi_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [3:0]       wrLow,
  input  logic             rdClearMode,
  input  logic             xferReq,
  input  logic             xferToMem,
  input  logic             cmdDir,
  output dmaStrobe_t       strb,
  output logic             dmaEnable
);
  dmaOp_e op;
  logic   cmdHit;

  assign op     = dmaOp_e'(wrLow[1:0]);
  assign cmdHit = regWrEn && (regIdx == IDX_CMD);

  always_comb begin
    strb         = '0;
    strb.cmdWr   = cmdHit;
    strb.startGo = cmdHit && (op == OP_START);
    strb.abortGo = cmdHit && (op == OP_ABORT);
    strb.stCntWr = regWrEn && (regIdx == IDX_ST_CNT);
    strb.stAdrWr = regWrEn && (regIdx == IDX_ST_ADR);
    strb.stMdlWr = regWrEn && (regIdx == IDX_ST_MDL);
    if (rdClearMode) begin
      if (regRdEn && (regIdx == IDX_STATUS)) strb.statClr = '1;
    end else begin
      if (regWrEn && (regIdx == IDX_STATUS)) strb.statClr = wrLow[3:1];
    end
    strb.xferGo  = xferReq && (xferToMem == cmdDir);
    strb.xferBad = xferReq && (xferToMem != cmdDir);
  end

  always_ff @(posedge clk) begin
    if (!rstN) dmaEnable <= 1'b0;
    else if (cmdHit && (op == OP_START)) dmaEnable <= 1'b1;
    else if (cmdHit && (op == OP_IDLE))  dmaEnable <= 1'b0;
  end
endmodule

// File: rtl/scsi_dma_datapath.sv
module scsi_dma_datapath
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strb,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] xferLen,
  input  logic              coreIrq,
  input  logic              cmdDone,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] xferGrantLen,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] workCnt,
  output logic [ST_W-1:0]   statusBits,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] WK_ADR_RST = '1;
  localparam logic [DATA_W-1:0] WK_MDL_RST = ~DATA_W'(2);

  logic [DATA_W-1:0] startCnt, startAdr, startMdl, workAdr, workMdl, grant;
  logic [ST_W-1:0]   statNext;

  assign grant        = (xferLen < workCnt) ? xferLen : workCnt;
  assign xferGrantLen = strb.xferGo ? grant : '0;

  always_comb begin
    statNext = strb.startGo ? '0 : statusBits;
    statNext = statNext & ~strb.statClr;
    if (strb.xferBad) statNext[0] = 1'b1;
    if (strb.abortGo) statNext[1] = 1'b1;
    if (cmdDone)      statNext[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg     <= '0;
      startCnt   <= '0;
      startAdr   <= '0;
      startMdl   <= '0;
      workCnt    <= '0;
      workAdr    <= WK_ADR_RST;
      workMdl    <= WK_MDL_RST;
      statusBits <= '0;
    end else begin
      if (strb.cmdWr)   cmdReg   <= regWrData;
      if (strb.stCntWr) startCnt <= regWrData;
      if (strb.stAdrWr) startAdr <= regWrData;
      if (strb.stMdlWr) startMdl <= regWrData;
      if (strb.startGo)     workCnt <= startCnt;
      else if (cmdDone)     workCnt <= '0;
      else if (strb.xferGo) workCnt <= workCnt - grant;
      if (strb.startGo)     workAdr <= startAdr;
      else if (strb.xferGo) workAdr <= workAdr + grant;
      if (strb.startGo) workMdl <= startMdl;
      statusBits <= statNext;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regIdx)
      IDX_CMD:    regRdData = cmdReg;
      IDX_ST_CNT: regRdData = startCnt;
      IDX_ST_ADR: regRdData = startAdr;
      IDX_WK_CNT: regRdData = workCnt;
      IDX_WK_ADR: regRdData = workAdr;
      IDX_STATUS: regRdData = DATA_W'({coreIrq, statusBits, 1'b0});
      IDX_ST_MDL: regRdData = startMdl;
      default:    regRdData = workMdl;
    endcase
  end

  assign irqOut = (statusBits[2] && cmdReg[CMD_IEDONE]) || (coreIrq && cmdReg[CMD_IECORE]);
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rdClearMode,
  input  logic              xferReq,
  input  logic              xferToMem,
  input  logic [DATA_W-1:0] xferLen,
  output logic              xferAccept,
  output logic [DATA_W-1:0] xferGrantLen,
  input  logic              coreIrq,
  input  logic              cmdDone,
  output logic              dmaEnable,
  output logic              abortReq,
  output logic              irqOut
);
  dmaStrobe_t        strb;
  logic [DATA_W-1:0] cmdReg, workCnt;
  logic [ST_W-1:0]   statusBits;
  logic              cmdDir;

  assign cmdDir     = cmdReg[CMD_DIR_BIT];
  assign xferAccept = strb.xferGo;
  assign abortReq   = strb.abortGo;

  scsi_dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regIdx(regIdx),
    .wrLow(regWrData[3:0]), .rdClearMode(rdClearMode), .xferReq(xferReq),
    .xferToMem(xferToMem), .cmdDir(cmdDir), .strb(strb), .dmaEnable(dmaEnable)
  );

  scsi_dma_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regIdx(regIdx), .regWrData(regWrData),
    .xferLen(xferLen), .coreIrq(coreIrq), .cmdDone(cmdDone), .regRdData(regRdData),
    .xferGrantLen(xferGrantLen), .cmdReg(cmdReg), .workCnt(workCnt),
    .statusBits(statusBits), .irqOut(irqOut)
  );
endmodule

// File: rtl/scsi_dma_regs_chk.sv
module scsi_dma_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regIdx,
  input logic [DATA_W-1:0] regWrData,
  input logic              rdClearMode,
  input logic              xferReq,
  input logic              xferToMem,
  input logic              xferAccept,
  input logic [DATA_W-1:0] xferGrantLen,
  input logic [DATA_W-1:0] workCnt,
  input logic [2:0]        statusBits,
  input logic              cmdDone,
  input logic              dmaEnable,
  input logic              cmdDir
);
  assert_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regIdx == 3'd0 && regWrData[1:0] == 2'b11 && !cmdDone && !xferReq)
    |=> (dmaEnable && statusBits == 3'b000));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regIdx == 3'd0 && regWrData[1:0] == 2'b00) |=> !dmaEnable);

  assert_clamp_R5: assert property (@(posedge clk) disable iff (!rstN)
    xferAccept |-> (xferGrantLen <= workCnt));

  assert_dir_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferToMem != cmdDir) |-> (!xferAccept && xferGrantLen == '0));

  assert_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !(regWrEn && regIdx == 3'd0))
    |=> (workCnt == '0 && statusBits[2]));

  assert_rdclear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdClearMode && regRdEn && regIdx == 3'd5 && !regWrEn && !cmdDone && !xferReq)
    |=> (statusBits == 3'b000));
endmodule

bind scsi_dma_regs scsi_dma_regs_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regIdx(regIdx),
  .regWrData(regWrData), .rdClearMode(rdClearMode), .xferReq(xferReq),
  .xferToMem(xferToMem), .xferAccept(xferAccept), .xferGrantLen(xferGrantLen),
  .workCnt(workCnt), .statusBits(statusBits), .cmdDone(cmdDone),
  .dmaEnable(dmaEnable), .cmdDir(cmdDir)
);

// File: tb/sim_scsi_dma_regs.sv
module sim_scsi_dma_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        rdClearMode = 1'b0;
  logic        xferReq = 1'b0, xferToMem = 1'b0;
  logic [31:0] xferLen = '0, xferGrantLen;
  logic        xferAccept, coreIrq = 1'b0, cmdDone = 1'b0;
  logic        dmaEnable, abortReq, irqOut;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0] mCmd, mStCnt, mStAdr, mWCnt, mWAdr, mStMdl, mWMdl;
  logic [2:0]  mStat;
  logic        mEn;

  always #10 clk = ~clk;

  scsi_dma_regs u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .rdClearMode(rdClearMode),
    .xferReq(xferReq), .xferToMem(xferToMem), .xferLen(xferLen),
    .xferAccept(xferAccept), .xferGrantLen(xferGrantLen), .coreIrq(coreIrq),
    .cmdDone(cmdDone), .dmaEnable(dmaEnable), .abortReq(abortReq), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [2:0] idx);
    case (idx)
      3'd0: return mCmd;
      3'd1: return mStCnt;
      3'd2: return mStAdr;
      3'd3: return mWCnt;
      3'd4: return mWAdr;
      3'd5: return {27'd0, coreIrq, mStat, 1'b0};
      3'd6: return mStMdl;
      default: return mWMdl;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkOuts(input string req);
    @(negedge clk); #1;
    chk({req, " enable"}, {31'd0, dmaEnable}, {31'd0, mEn});
    chk("R11 irqOut", {31'd0, irqOut},
        {31'd0, (mStat[2] & mCmd[6]) | (coreIrq & mCmd[5])});
  endtask

  task automatic rd(input string req, input logic [2:0] idx);
    @(negedge clk);
    regRdEn = 1'b1; regIdx = idx; #1;
    chk(req, regRdData, expRead(idx));
    @(posedge clk); #1;
    regRdEn = 1'b0;
    if (idx == 3'd5 && rdClearMode) mStat = '0;
  endtask

  task automatic wr(input string req, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = idx; regWrData = d; #1;
    if (idx == 3'd0) chk({req, " R4 abortReq"}, {31'd0, abortReq}, {31'd0, d[1:0] == 2'd2});
    @(posedge clk); #1;
    regWrEn = 1'b0;
    case (idx)
      3'd0: begin
        mCmd = d;
        case (d[1:0])
          2'd0: mEn = 1'b0;
          2'd2: mStat[1] = 1'b1;
          2'd3: begin mWCnt = mStCnt; mWAdr = mStAdr; mWMdl = mStMdl; mStat = '0; mEn = 1'b1; end
          default: ;
        endcase
      end
      3'd1: mStCnt = d;
      3'd2: mStAdr = d;
      3'd5: if (!rdClearMode) mStat = mStat & ~d[3:1];
      3'd6: mStMdl = d;
      default: ;
    endcase
  endtask

  task automatic xfer(input logic toMem, input logic [31:0] len);
    logic ok;
    logic [31:0] g;
    ok = (toMem == mCmd[7]);
    g  = ok ? ((len < mWCnt) ? len : mWCnt) : 32'd0;
    @(negedge clk);
    xferReq = 1'b1; xferToMem = toMem; xferLen = len; #1;
    chk(ok ? "R5 accept" : "R6 accept", {31'd0, xferAccept}, {31'd0, ok});
    chk(ok ? "R5 grant" : "R6 grant", xferGrantLen, g);
    @(posedge clk); #1;
    xferReq = 1'b0;
    if (ok) begin mWCnt = mWCnt - g; mWAdr = mWAdr + g; end
    else mStat[0] = 1'b1;
  endtask

  task automatic done();
    @(negedge clk);
    cmdDone = 1'b1;
    @(posedge clk); #1;
    cmdDone = 1'b0;
    mWCnt = '0; mStat[2] = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    mCmd = '0; mStCnt = '0; mStAdr = '0; mWCnt = '0; mWAdr = 32'hFFFF_FFFF;
    mStMdl = '0; mWMdl = 32'hFFFF_FFFD; mStat = '0; mEn = 1'b0;
    void'($urandom(32'h1DA5_0C0D));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    for (int i = 0; i < 8; i++) rd("R1 reset read", 3'(i));
    chkOuts("R1");

    // R2 writable and read-only registers
    wr("R2", 3'd1, 32'd100);
    wr("R2", 3'd2, 32'h0000_1000);
    wr("R2", 3'd6, 32'h0000_0020);
    wr("R2", 3'd3, 32'hDEAD_BEEF);
    wr("R2", 3'd4, 32'h1234_5678);
    wr("R2", 3'd7, 32'h0BAD_0BAD);
    for (int i = 1; i < 8; i++) if (i != 5) rd("R2 readback", 3'(i));

    // R3 start with direction to memory, done irq enabled
    wr("R3", 3'd0, 32'h0000_00C3);
    rd("R3 count", 3'd3); rd("R3 addr", 3'd4); rd("R3 mdl", 3'd7);
    chkOuts("R3");

    // R5 transfers including clamp and empty count
    xfer(1'b1, 32'd40);
    xfer(1'b1, 32'd100);
    xfer(1'b1, 32'd5);
    rd("R5 count", 3'd3); rd("R5 addr", 3'd4);

    // R6 wrong direction
    xfer(1'b0, 32'd8);
    rd("R6 status", 3'd5);

    // R9 write-one-to-clear
    wr("R9", 3'd5, 32'h0000_0002);
    rd("R9 status", 3'd5);

    // R7 and R11 done with irq enable
    wr("R3", 3'd0, 32'h0000_00C3);
    done();
    rd("R7 count", 3'd3); rd("R7 status", 3'd5);
    chkOuts("R7");

    // R8 core interrupt merged, not stored; R11 core irq enable
    coreIrq = 1'b1;
    wr("R4 blast", 3'd0, 32'h0000_0021);
    rd("R8 status", 3'd5);
    chkOuts("R4 blast");
    coreIrq = 1'b0;
    rd("R8 status after", 3'd5);

    // R10 clear on read, writes ignored
    rdClearMode = 1'b1;
    wr("R4 abort", 3'd0, 32'h0000_0002);
    wr("R10", 3'd5, 32'h0000_000E);
    rd("R10 first read", 3'd5);
    rd("R10 second read", 3'd5);
    wr("R4 idle", 3'd0, 32'h0000_0000);
    chkOuts("R4 idle");
    rdClearMode = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned sel;
      sel = $urandom_range(0, 9);
      coreIrq = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) rdClearMode = ~rdClearMode;
      case (sel)
        0: wr("R4 rand cmd", 3'd0, {24'd0, 8'($urandom)});
        1: wr("R2 rand", 3'($urandom_range(0, 7)), $urandom);
        2: wr("R3 rand start", 3'd0, {24'd0, 1'($urandom), 2'($urandom), 3'd0, 2'd3});
        3: wr("R2 rand cnt", 3'd1, 32'($urandom_range(0, 300)));
        4, 5: xfer(1'($urandom_range(0, 1)), 32'($urandom_range(0, 80)));
        6: done();
        7: wr("R9 rand", 3'd5, {28'd0, 4'($urandom)});
        default: rd("R2 rand read", 3'($urandom_range(0, 7)));
      endcase
      rd("R8 rand status", 3'd5);
      chkOuts("R4 rand");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule